// File: doc/BRIEF.md
# Parallel-Port ECP Forward Write Engine

This block sends a burst of data bytes from the host to a peripheral over a parallel port running in ECP forward mode. It drives the handshake lines itself, so software does not have to toggle them. A transfer starts with a one-cycle `start_i` pulse that carries a byte count and three cycle limits. The engine then pulls bytes from a valid/ready stream. For each byte it places the byte on the data lines and waits a setup delay. It then asserts the host clock strobe and waits for the peripheral's busy line to rise, which is the first handshake phase. It releases the strobe and waits for busy to fall, which is the second phase.

Each handshake phase has its own timeout, and the two expiries report different outcomes. If busy never appears, the engine reports a busy-timeout status. If busy never clears, it reports an I/O error. An I/O error can also raise a bus-reset pulse of fixed width, selected at build time. Every exit reports the number of bytes that completed both phases, and a wrapping running total adds that number on each exit.

Top module: `ecp_fwd_writer`

## Requirements
- R1: After reset the strobe `host_clk_no` is high (released), `host_ack_o` is high, `s_ready_o`, `done_o`, `active_o` and `bus_rst_o` are low, and `total_o` is zero.
- R2: `host_ack_o` is high (data level) on every cycle in which the strobe is low (asserted).
- R3: A byte is taken only on a cycle with `s_valid_i` and `s_ready_o` both high. It appears on `pd_o` when the strobe falls and stays unchanged until the strobe rises. `s_ready_o` is never high while the strobe is low.
- R4: The strobe falls exactly max(`setup_cyc_i`,1) cycles after the clock edge that takes the byte.
- R5: When `periph_ack_i` is high (busy) during a strobe-low cycle, the strobe is high in the next cycle.
- R6: If busy is not seen, the strobe stays low for exactly `busy_tmo_i`+1 cycles. The transfer then ends with `status_o`=1 and the strobe released.
- R7: Busy that is first present on the last allowed strobe cycle (cycle `busy_tmo_i`+1) counts as seen, not as a timeout.
- R8: After the strobe is released, if busy stays high for `idle_tmo_i`+1 cycles, the transfer ends with `status_o`=2. Busy that falls on or before that cycle completes the byte.
- R9: A byte counts as transferred when busy falls. After `len_i` bytes the transfer ends with `status_o`=0 and `xfer_cnt_o`=`len_i`. With `len_i`=0 it ends at once with count 0. On a timeout, `xfer_cnt_o` is the number of bytes completed before the failing byte.
- R10: On every exit, `total_o` already holds its previous value plus `xfer_cnt_o`, modulo 2^TOT_W, in the cycle where `done_o` is high.
- R11: With ERR_RST=1, `bus_rst_o` is high for exactly RST_W cycles, starting in the `done_o` cycle of an I/O-error exit. It is never high otherwise.
- R12: `start_i` and all transfer inputs are ignored while `active_o` is high, because the count and the limits are captured at start.
- R13: `done_o` is a one-cycle pulse. `status_o` and `xfer_cnt_o` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| len_i | input | CNT_W | Number of bytes to send |
| setup_cyc_i | input | TMO_W | Cycles from data drive to strobe (0 treated as 1) |
| busy_tmo_i | input | TMO_W | Busy-wait limit, strobe held for this value plus one cycle |
| idle_tmo_i | input | TMO_W | Busy-release wait limit, this value plus one cycle |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DW | Stream byte |
| s_ready_o | output | 1 | Engine takes a byte this cycle when valid |
| pd_o | output | DW | Parallel data lines |
| host_clk_no | output | 1 | Host clock strobe, low = asserted |
| host_ack_o | output | 1 | Host acknowledge, high = data byte |
| periph_ack_i | input | 1 | Peripheral busy, high = busy |
| bus_rst_o | output | 1 | Bus-reset pulse after an I/O error |
| active_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 2 | 0 success, 1 busy timeout, 2 I/O error |
| xfer_cnt_o | output | CNT_W | Bytes completed in the last transfer |
| total_o | output | TOT_W | Wrapping running total of completed bytes |

## Verification
A wrong wait-timer value shows at the ports within one phase. The strobe-low run then differs from `busy_tmo_i`+1, or the release wait from `idle_tmo_i`+1, and the status code of that same transfer is wrong. A wrong byte counter shows on `xfer_cnt_o` and `total_o` in the `done_o` cycle. A data register that was loaded at the wrong moment shows on `pd_o` at the first strobe-low cycle of that byte. The sweeps cover every setup, busy and release delay around each limit in a small range, so an off-by-one in any phase changes a strobe-run length, a status or a count on the same transfer.

// File: rtl/ecp_wr_pkg.sv
package ecp_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_STROBE, ST_RELEASE, ST_DONE
  } wr_state_e;

  typedef enum logic [1:0] {
    WR_OK       = 2'd0,
    WR_BUSY_TMO = 2'd1,
    WR_IO_ERR   = 2'd2
  } wr_status_e;
endpackage

// File: rtl/ecp_wait_timer.sv
module ecp_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ecp_pulse_gen.sv
module ecp_pulse_gen #(
  parameter int WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);
  logic [CW-1:0] cnt_q;

  assign pulse_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (trig_i)  cnt_q <= CW'(WIDTH);
    else if (pulse_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ecp_wrap_accum.sv
module ecp_wrap_accum #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic [AW-1:0] val_i,
  output logic [W-1:0]  sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (add_i) sum_o <= sum_o + W'(val_i);
  end
endmodule

// File: rtl/ecp_fwd_writer.sv
module ecp_fwd_writer
  import ecp_wr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CNT_W   = 16,
  parameter int TMO_W   = 16,
  parameter int TOT_W   = 32,
  parameter bit ERR_RST = 1'b1,
  parameter int RST_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [TMO_W-1:0] setup_cyc_i,
  input  logic [TMO_W-1:0] busy_tmo_i,
  input  logic [TMO_W-1:0] idle_tmo_i,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic [DW-1:0]    pd_o,
  output logic             host_clk_no,
  output logic             host_ack_o,
  input  logic             periph_ack_i,
  output logic             bus_rst_o,
  output logic             active_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [CNT_W-1:0] xfer_cnt_o,
  output logic [TOT_W-1:0] total_o
);
  wr_state_e        state_q, state_d;
  wr_status_e       status_q, status_d;
  logic [CNT_W-1:0] len_q, cnt_q;
  logic [TMO_W-1:0] setup_q, btmo_q, itmo_q, lim;
  logic [DW-1:0]    pd_q;
  logic             ack_lvl_q;
  logic             tmr_exp, take, byte_ok, enter_done, io_err_hit;

  assign s_ready_o  = (state_q == ST_FETCH) && (cnt_q != len_q);
  assign take       = s_ready_o && s_valid_i;
  assign byte_ok    = (state_q == ST_RELEASE) && !periph_ack_i;
  assign enter_done = (state_d == ST_DONE) && (state_q != ST_DONE);
  assign io_err_hit = enter_done && (status_d == WR_IO_ERR);

  // per-phase limit on one shared timer
  always_comb begin
    unique case (state_q)
      ST_SETUP:   lim = (setup_q == '0) ? '0 : setup_q - 1'b1;
      ST_STROBE:  lim = btmo_q;
      ST_RELEASE: lim = itmo_q;
      default:    lim = '0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: begin
        if (cnt_q == len_q) begin
          state_d  = ST_DONE;
          status_d = WR_OK;
        end else if (s_valid_i) begin
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: if (tmr_exp) state_d = ST_STROBE;
      ST_STROBE: begin
        // busy is tested before expiry: last-cycle arrival wins
        if (periph_ack_i) begin
          state_d = ST_RELEASE;
        end else if (tmr_exp) begin
          state_d  = ST_DONE;
          status_d = WR_BUSY_TMO;
        end
      end
      ST_RELEASE: begin
        if (!periph_ack_i) begin
          state_d = ST_FETCH;
        end else if (tmr_exp) begin
          state_d  = ST_DONE;
          status_d = WR_IO_ERR;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      status_q  <= WR_OK;
      len_q     <= '0;
      cnt_q     <= '0;
      setup_q   <= '0;
      btmo_q    <= '0;
      itmo_q    <= '0;
      pd_q      <= '0;
      ack_lvl_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (state_q == ST_IDLE && start_i) begin
        len_q   <= len_i;
        setup_q <= setup_cyc_i;
        btmo_q  <= busy_tmo_i;
        itmo_q  <= idle_tmo_i;
        cnt_q   <= '0;
      end
      if (take) begin
        pd_q      <= s_data_i;
        ack_lvl_q <= 1'b1;
      end
      if (byte_ok) cnt_q <= cnt_q + 1'b1;
    end
  end

  ecp_wait_timer #(.W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_d != state_q),
    .limit_i  (lim),
    .expired_o(tmr_exp)
  );

  ecp_wrap_accum #(.W(TOT_W), .AW(CNT_W)) u_total (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .add_i (enter_done),
    .val_i (cnt_q),
    .sum_o (total_o)
  );

  generate
    if (ERR_RST) begin : g_bus_rst
      ecp_pulse_gen #(.WIDTH(RST_W)) u_pulse (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (io_err_hit),
        .pulse_o(bus_rst_o)
      );
    end else begin : g_no_bus_rst
      assign bus_rst_o = 1'b0;
    end
  endgenerate

  assign pd_o        = pd_q;
  assign host_clk_no = (state_q != ST_STROBE);
  assign host_ack_o  = ack_lvl_q;
  assign active_o    = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign status_o    = status_q;
  assign xfer_cnt_o  = cnt_q;
endmodule

// File: rtl/ecp_fwd_writer_chk.sv
module ecp_fwd_writer_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  parameter int TOT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_ready_o,
  input logic [DW-1:0]    pd_o,
  input logic             host_clk_no,
  input logic             host_ack_o,
  input logic             periph_ack_i,
  input logic             bus_rst_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic [CNT_W-1:0] xfer_cnt_o,
  input logic [TOT_W-1:0] total_o
);
  p_ack_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_clk_no |-> host_ack_o);

  p_pd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_clk_no && !$past(host_clk_no)) |-> $stable(pd_o));

  p_no_ready_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_ready_o && !host_clk_no));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_clk_no && periph_ack_i) |=> host_clk_no);

  p_busy_tmo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |-> !$past(host_clk_no));

  p_total_sum_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (total_o == $past(total_o) + TOT_W'(xfer_cnt_o)));

  p_rst_on_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rst_o) |-> (done_o && status_o == 2'd2));

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind ecp_fwd_writer ecp_fwd_writer_chk #(
  .DW(DW), .CNT_W(CNT_W), .TOT_W(TOT_W)
) u_chk (
  .clk_i, .rst_ni, .s_ready_o, .pd_o, .host_clk_no, .host_ack_o,
  .periph_ack_i, .bus_rst_o, .done_o, .status_o, .xfer_cnt_o, .total_o
);

// File: tb/tb_ecp_fwd_writer.sv
`timescale 1ns/1ps
module tb_ecp_fwd_writer;
  localparam int DW = 8, CNT_W = 16, TMO_W = 16, TOT_W = 8, RST_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             start_i;
  logic [CNT_W-1:0] len_i;
  logic [TMO_W-1:0] setup_cyc_i, busy_tmo_i, idle_tmo_i;
  logic             s_valid_i;
  logic [DW-1:0]    s_data_i;
  logic             s_ready_o, host_clk_no, host_ack_o, bus_rst_o;
  logic             active_o, done_o;
  logic             pa;
  logic [DW-1:0]    pd_o;
  logic [1:0]       status_o;
  logic [CNT_W-1:0] xfer_cnt_o;
  logic [TOT_W-1:0] total_o;

  int checks = 0, fails = 0;
  int src_idx = 0;

  function automatic logic [7:0] byte_of(int i);
    return 8'(i * 37 + 11);
  endfunction

  assign s_data_i = byte_of(src_idx);

  ecp_fwd_writer #(
    .DW(DW), .CNT_W(CNT_W), .TMO_W(TMO_W), .TOT_W(TOT_W),
    .ERR_RST(1'b1), .RST_W(RST_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .len_i(len_i),
    .setup_cyc_i(setup_cyc_i), .busy_tmo_i(busy_tmo_i), .idle_tmo_i(idle_tmo_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .pd_o(pd_o), .host_clk_no(host_clk_no), .host_ack_o(host_ack_o),
    .periph_ack_i(pa), .bus_rst_o(bus_rst_o), .active_o(active_o),
    .done_o(done_o), .status_o(status_o), .xfer_cnt_o(xfer_cnt_o),
    .total_o(total_o)
  );

  // peripheral and source model state
  int  rise_after, fall_after, fail_byte, pi;
  int  lowcnt, hicnt, last_low, rel_cnt, rst_hi;
  int  setup_cnt, last_setup, data_bad, ack_bad;
  bit  hs_pend, meas_setup, stall_mode;
  logic [7:0] exp_pd;
  int  tot_exp = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int ra, fa;
    if (hs_pend) begin
      src_idx++;
      hs_pend    = 1'b0;
      setup_cnt  = 0;
      meas_setup = 1'b1;
    end
    s_valid_i = stall_mode ? ~s_valid_i : 1'b1;
    if (meas_setup) begin
      if (host_clk_no) setup_cnt++;
      else begin
        last_setup = setup_cnt;
        meas_setup = 1'b0;
      end
    end
    if (s_valid_i && s_ready_o) begin
      hs_pend = 1'b1;
      exp_pd  = byte_of(src_idx);
    end
    if (!host_clk_no) begin
      if (lowcnt == 0 && pd_o != exp_pd) data_bad++;
      if (!host_ack_o) ack_bad++;
      lowcnt++;
      rel_cnt = 0;
      if (!pa) begin
        ra = (pi < fail_byte) ? 1 : rise_after;
        if (ra >= 1 && lowcnt >= ra) pa = 1'b1;
      end
    end else begin
      if (lowcnt != 0) begin
        last_low = lowcnt;
        lowcnt   = 0;
      end
      if (pa) begin
        if (!done_o) rel_cnt++;
        hicnt++;
        fa = (pi < fail_byte) ? 1 : fall_after;
        if (fa >= 1 && hicnt >= fa) begin
          pa    = 1'b0;
          hicnt = 0;
          pi++;
        end
      end
    end
    if (bus_rst_o) rst_hi++;
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
  endtask

  // ra/fa of 0 = peripheral never responds in that phase
  task automatic run(int len, int su, int bt, int it, int ra, int fa, int fb,
                     bit stall, bit restart);
    int n, exp_st, exp_cnt, exp_low;
    bit busy_ok, idle_ok;
    pi = 0; pa = 1'b0; lowcnt = 0; hicnt = 0; last_low = 0; rel_cnt = 0;
    rst_hi = 0; last_setup = -1; data_bad = 0; ack_bad = 0;
    rise_after = ra; fall_after = fa; fail_byte = fb; stall_mode = stall;
    len_i = CNT_W'(len); setup_cyc_i = TMO_W'(su);
    busy_tmo_i = TMO_W'(bt); idle_tmo_i = TMO_W'(it);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    if (restart) begin
      repeat (3) tick();
      len_i = CNT_W'(len + 5); busy_tmo_i = '0; start_i = 1'b1;
      tick();
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 5000) begin
      tick();
      n++;
    end
    chk("R9 done reached", done_o, 1);

    busy_ok = (ra >= 1) && (ra <= bt + 1);
    idle_ok = (fa >= 1) && (fa <= it + 1);
    if (fb >= len)     begin exp_st = 0; exp_cnt = len; end
    else if (!busy_ok) begin exp_st = 1; exp_cnt = fb;  end
    else if (!idle_ok) begin exp_st = 2; exp_cnt = fb;  end
    else               begin exp_st = 0; exp_cnt = len; end

    chk($sformatf("R9 status len=%0d ra=%0d fa=%0d", len, ra, fa), status_o, exp_st);
    chk("R9 count", xfer_cnt_o, exp_cnt);
    tot_exp = (tot_exp + exp_cnt) % (1 << TOT_W);
    chk("R10 total", total_o, tot_exp);
    if (len > 0) begin
      chk($sformatf("R4 setup su=%0d", su), last_setup, (su == 0) ? 1 : su);
      chk("R3 data on lines", data_bad, 0);
      chk("R2 ack level", ack_bad, 0);
      if (exp_st == 1) exp_low = bt + 1;
      else if (fb < len) exp_low = ra;
      else exp_low = 1;
      chk($sformatf("R5 R6 R7 strobe run bt=%0d ra=%0d", bt, ra), last_low, exp_low);
    end
    if (exp_st == 2) chk("R8 release wait", rel_cnt, it + 1);
    tick();
    chk("R13 done one cycle", done_o, 0);
    chk("R13 status held", status_o, exp_st);
    chk("R13 count held", xfer_cnt_o, exp_cnt);
    repeat (RST_W + 2) tick();
    chk("R11 bus reset width", rst_hi, (exp_st == 2) ? RST_W : 0);
  endtask

  task automatic summary(int extra);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + extra);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R9 watchdog act=hung exp=finished");
    summary(1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; s_valid_i = 1'b0; pa = 1'b0;
    len_i = '0; setup_cyc_i = '0; busy_tmo_i = '0; idle_tmo_i = '0;
    exp_pd = '0; hs_pend = 1'b0; meas_setup = 1'b0; stall_mode = 1'b0;
    rise_after = 1; fall_after = 1; fail_byte = 0; pi = 0;
    lowcnt = 0; hicnt = 0; last_low = 0; rel_cnt = 0; rst_hi = 0;
    setup_cnt = 0; last_setup = 0; data_bad = 0; ack_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe released", host_clk_no, 1);
    chk("R1 ack level", host_ack_o, 1);
    chk("R1 ready low", s_ready_o, 0);
    chk("R1 done low", done_o, 0);
    chk("R1 idle", active_o, 0);
    chk("R1 bus reset low", bus_rst_o, 0);
    chk("R1 total zero", total_o, 0);

    run(0, 1, 2, 2, 1, 1, 0, 0, 0);                   // R9 empty transfer
    for (int bt = 0; bt < 4; bt++)                    // R6 R7 sweep
      for (int su = 0; su < 3; su++)
        for (int ra = 1; ra <= bt + 2; ra++)
          run(3, su, bt, 2, ra, 1, 1, 0, 0);
    run(2, 1, 5, 2, 0, 1, 0, 0, 0);                   // R6 never busy
    for (int it = 0; it < 4; it++)                    // R8 sweep
      for (int fa = 1; fa <= it + 2; fa++)
        run(3, 1, 2, it, 1, fa, 2, 0, 0);
    run(2, 2, 2, 3, 1, 0, 1, 0, 0);                   // R8 R11 never clears
    run(6, 2, 3, 3, 2, 2, 0, 1, 0);                   // R3 stalled stream
    run(4, 1, 3, 3, 2, 2, 0, 0, 1);                   // R12 restart ignored
    run(200, 0, 0, 0, 1, 1, 200, 0, 0);               // R10 wrap
    run(200, 0, 0, 0, 1, 1, 200, 0, 0);

    summary(0);
    $finish;
  end
endmodule